// File: doc/BRIEF.md
# Cascadable Line Data Loader

This block gathers one display line of pixel bits into an internal line buffer, one parallel word per transfer. A width select picks full-width transfers (8 bits) or half-width transfers (4 bits, upper data bits ignored). A fill-direction select picks the end of the line where filling starts. It also picks which of two chain enable pins is read as the enable input and which one drives the enable output. The block keeps a running position and places each word at the next free slot.

Devices are cascaded through the active-low chain enable. A device takes data only while its enable input is low. When it captures the last word of its line, it drives its enable output low, which arms the next device. It then refuses further data until a line-start pulse (the system-clock form of the load strobe) rewinds the position and releases the enable output. Data arrives on a valid/ready pair. `in_valid` means `in_data` holds a word. `in_ready` is high only while capture is armed and the enable input is low. A word is taken on a clock edge where both are high and `line_start` is low. A source facing low `in_ready` must hold its word. Everything is synchronous to `clk`. Each captured word appears on `line_o` after that edge.

Top module: `line_loader`

## Requirements
- R1: After reset, `line_o` is all zero, the position is at the start of the line, and the enable output of the active pin is high.
- R2: A word is captured only on an edge with `in_valid`, `in_ready` and not `line_start`. On every other edge `line_o` keeps its value. `in_ready` is high exactly when capture is armed and the enable input is low.
- R3: Full width, direction low: transfer k (from 0) writes `in_data[7-j]` to `line_o[8k+j]`, for j=0..7. Example: a first word 0xC1 gives `line_o[7:0]` = 0x83.
- R4: Half width, direction low: transfer k writes `in_data[3-j]` to `line_o[4k+j]`, for j=0..3. `in_data[7:4]` has no effect. Example: a first word 0xF2 gives `line_o[3:0]` = 0x4.
- R5: Direction high mirrors the fill. Full-width transfer k writes `in_data[j]` to `line_o[152-8k+j]`, so a first word 0xC1 gives `line_o[159:152]` = 0xC1. Half-width transfer k writes `in_data[j]` to `line_o[156-4k+j]`.
- R6: Direction low: pin A is the enable input (`chain_a_oe`=0, `chain_a_o`=1) and pin B is the enable output (`chain_b_oe`=1). Direction high swaps the two roles.
- R7: After 20 full-width or 40 half-width captures, the enable output is low from the next cycle. `in_ready` stays low and further words are not taken until `line_start`.
- R8: `line_start` rewinds the position, drives the enable output high and re-arms capture. A word offered in the same cycle is dropped.
- R9: While the enable input is high, `in_valid` changes neither `line_o` nor the position.
- R10: `line_start` does not clear `line_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wide | input | 1 | 1: 8-bit words, 0: 4-bit words |
| fill_dir | input | 1 | 0: fill from bit 0 upward, 1: fill from the top downward |
| line_start | input | 1 | One-cycle line rewind pulse |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Word can be taken |
| in_data | input | 8 | Data word |
| chain_a_i | input | 1 | Pin A level in (enable input when fill_dir=0) |
| chain_a_o | output | 1 | Pin A level out |
| chain_a_oe | output | 1 | Pin A output enable |
| chain_b_i | input | 1 | Pin B level in (enable input when fill_dir=1) |
| chain_b_o | output | 1 | Pin B level out |
| chain_b_oe | output | 1 | Pin B output enable |
| line_o | output | 160 | Line buffer contents |

## Verification
Two collisions can fall in one cycle. The first is a rewind together with an offered word. The bench raises `line_start` and `in_valid` on the same edge, once in the middle of a line and once with the line full. It then checks that the buffer is unchanged and that the next word lands at the start of the line. The second collision is the final capture together with a word still offered on the following cycle: the enable output must fall and the extra word must be dropped. A behavioural model compares buffer, ready and pin levels on every clock.

// File: rtl/lnld_pkg.sv
package lnld_pkg;
  typedef enum logic {
    FILL_UP   = 1'b0,
    FILL_DOWN = 1'b1
  } fill_dir_e;

  localparam int LINE_BITS_DEF = 160;
  localparam int BUS_W_DEF     = 8;
endpackage

// File: rtl/lnld_seq.sv
module lnld_seq #(
  parameter int LINE_BITS = lnld_pkg::LINE_BITS_DEF,
  parameter int BUS_W     = lnld_pkg::BUS_W_DEF,
  localparam int NARROW_W   = BUS_W / 2,
  localparam int STEPS_WIDE = LINE_BITS / BUS_W,
  localparam int STEPS_NAR  = LINE_BITS / NARROW_W,
  localparam int CW         = $clog2(STEPS_NAR + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wide,
  input  logic          line_start,
  input  logic          in_valid,
  input  logic          en_in_n,
  output logic          in_ready,
  output logic          accept,
  output logic [CW-1:0] step,
  output logic          en_out_n
);
  localparam logic [CW-1:0] LAST_WIDE = CW'(STEPS_WIDE - 1);
  localparam logic [CW-1:0] LAST_NAR  = CW'(STEPS_NAR - 1);

  logic          armed;
  logic [CW-1:0] last_step;
  logic          at_last;

  assign last_step = bus_wide ? LAST_WIDE : LAST_NAR;
  assign at_last   = (step >= last_step);
  assign in_ready  = armed & ~en_in_n;
  assign accept    = in_valid & in_ready & ~line_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step     <= '0;
      armed    <= 1'b1;
      en_out_n <= 1'b1;
    end else if (line_start) begin
      step     <= '0;
      armed    <= 1'b1;
      en_out_n <= 1'b1;
    end else if (accept) begin
      if (at_last) begin
        armed    <= 1'b0;
        en_out_n <= 1'b0;
      end else begin
        step <= step + 1'b1;
      end
    end
  end

  p_full_hands_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && at_last) |=> (!en_out_n && !in_ready))
    else $error("R7 enable not handed on");

  p_done_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_out_n && !line_start) |=> !en_out_n)
    else $error("R7 enable output released early");

  p_rewind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (step == '0 && en_out_n))
    else $error("R8 rewind failed");

  p_idle_when_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_in_n && !line_start) |=> $stable(step))
    else $error("R9 position moved while disabled");
endmodule

// File: rtl/lnld_place.sv
module lnld_place #(
  parameter int LINE_BITS = lnld_pkg::LINE_BITS_DEF,
  parameter int BUS_W     = lnld_pkg::BUS_W_DEF,
  localparam int NARROW_W = BUS_W / 2,
  localparam int CW       = $clog2(LINE_BITS / NARROW_W + 1)
) (
  input  logic                 bus_wide,
  input  lnld_pkg::fill_dir_e  fill_dir,
  input  logic                 accept,
  input  logic [CW-1:0]        step,
  input  logic [BUS_W-1:0]     data,
  output logic [LINE_BITS-1:0] we,
  output logic [LINE_BITS-1:0] wd
);
  for (genvar p = 0; p < LINE_BITS; p++) begin : g_bit
    localparam int UP     = p;
    localparam int DN     = LINE_BITS - 1 - p;
    localparam int UW_STP = UP / BUS_W;
    localparam int UW_SEL = BUS_W - 1 - (UP % BUS_W);
    localparam int DW_STP = DN / BUS_W;
    localparam int DW_SEL = BUS_W - 1 - (DN % BUS_W);
    localparam int UN_STP = UP / NARROW_W;
    localparam int UN_SEL = NARROW_W - 1 - (UP % NARROW_W);
    localparam int DN_STP = DN / NARROW_W;
    localparam int DN_SEL = NARROW_W - 1 - (DN % NARROW_W);

    logic hit_w, hit_n, bit_w, bit_n;

    always_comb begin
      if (fill_dir == lnld_pkg::FILL_DOWN) begin
        hit_w = (int'(step) == DW_STP);
        bit_w = data[DW_SEL];
        hit_n = (int'(step) == DN_STP);
        bit_n = data[DN_SEL];
      end else begin
        hit_w = (int'(step) == UW_STP);
        bit_w = data[UW_SEL];
        hit_n = (int'(step) == UN_STP);
        bit_n = data[UN_SEL];
      end
    end

    assign we[p] = accept & (bus_wide ? hit_w : hit_n);
    assign wd[p] = bus_wide ? bit_w : bit_n;
  end
endmodule

// File: rtl/lnld_store.sv
module lnld_store #(
  parameter int LINE_BITS = lnld_pkg::LINE_BITS_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LINE_BITS-1:0] we,
  input  logic [LINE_BITS-1:0] wd,
  output logic [LINE_BITS-1:0] line_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
    end else begin
      for (int p = 0; p < LINE_BITS; p++) begin
        if (we[p]) line_q[p] <= wd[p];
      end
    end
  end

  p_unwritten_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(|we) |=> $stable(line_q))
    else $error("R2 buffer changed without a write");
endmodule

// File: rtl/line_loader.sv
module line_loader #(
  parameter int LINE_BITS = lnld_pkg::LINE_BITS_DEF,
  parameter int BUS_W     = lnld_pkg::BUS_W_DEF,
  localparam int NARROW_W = BUS_W / 2,
  localparam int CW       = $clog2(LINE_BITS / NARROW_W + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wide,
  input  logic                 fill_dir,
  input  logic                 line_start,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [BUS_W-1:0]     in_data,
  input  logic                 chain_a_i,
  output logic                 chain_a_o,
  output logic                 chain_a_oe,
  input  logic                 chain_b_i,
  output logic                 chain_b_o,
  output logic                 chain_b_oe,
  output logic [LINE_BITS-1:0] line_o
);
  lnld_pkg::fill_dir_e  dir;
  logic                 en_in_n;
  logic                 en_out_n;
  logic                 accept;
  logic [CW-1:0]        step;
  logic [LINE_BITS-1:0] we;
  logic [LINE_BITS-1:0] wd;

  assign dir        = lnld_pkg::fill_dir_e'(fill_dir);
  assign en_in_n    = (dir == lnld_pkg::FILL_DOWN) ? chain_b_i : chain_a_i;
  assign chain_a_oe = (dir == lnld_pkg::FILL_DOWN);
  assign chain_b_oe = (dir == lnld_pkg::FILL_UP);
  assign chain_a_o  = chain_a_oe ? en_out_n : 1'b1;
  assign chain_b_o  = chain_b_oe ? en_out_n : 1'b1;

  lnld_seq #(.LINE_BITS(LINE_BITS), .BUS_W(BUS_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wide   (bus_wide),
    .line_start (line_start),
    .in_valid   (in_valid),
    .en_in_n    (en_in_n),
    .in_ready   (in_ready),
    .accept     (accept),
    .step       (step),
    .en_out_n   (en_out_n)
  );

  lnld_place #(.LINE_BITS(LINE_BITS), .BUS_W(BUS_W)) u_place (
    .bus_wide (bus_wide),
    .fill_dir (dir),
    .accept   (accept),
    .step     (step),
    .data     (in_data),
    .we       (we),
    .wd       (wd)
  );

  lnld_store #(.LINE_BITS(LINE_BITS)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (we),
    .wd     (wd),
    .line_q (line_o)
  );

  p_disabled_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_dir ? chain_b_i : chain_a_i) |-> !in_ready)
    else $error("R9 ready while enable input high");

  p_rewind_keeps_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> $stable(line_o))
    else $error("R10 rewind touched buffer");
endmodule

// File: tb/line_loader_bench.sv
module line_loader_bench;
  localparam int LB = 160;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wide = 1'b1;
  logic          fill_dir = 1'b0;
  logic          line_start = 1'b0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = '0;
  logic          chain_a_i = 1'b0;
  logic          chain_b_i = 1'b0;
  logic          in_ready, chain_a_o, chain_a_oe, chain_b_o, chain_b_oe;
  logic [LB-1:0] line_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  line_loader u_line_loader (
    .clk(clk), .rst_n(rst_n), .bus_wide(bus_wide), .fill_dir(fill_dir),
    .line_start(line_start), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .chain_a_i(chain_a_i), .chain_a_o(chain_a_o),
    .chain_a_oe(chain_a_oe), .chain_b_i(chain_b_i), .chain_b_o(chain_b_o),
    .chain_b_oe(chain_b_oe), .line_o(line_o)
  );

  // behavioural reference model
  logic [LB-1:0] m_line;
  int            m_pos;
  bit            m_armed;
  bit            m_done;

  function automatic bit m_ready();
    bit en_low;
    en_low = fill_dir ? !chain_b_i : !chain_a_i;
    return m_armed && en_low;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_line = '0; m_pos = 0; m_armed = 1; m_done = 0;
    end else if (line_start) begin
      m_pos = 0; m_armed = 1; m_done = 0;
    end else if (in_valid && m_ready()) begin
      int w;
      int lim;
      w   = bus_wide ? 8 : 4;
      lim = 160 / w;
      for (int j = 0; j < w; j++) begin
        int idx;
        idx = m_pos * w + j;
        if (fill_dir) idx = 159 - idx;
        m_line[idx] = in_data[w-1-j];
      end
      if (m_pos >= lim - 1) begin
        m_armed = 0; m_done = 1;
      end else begin
        m_pos = m_pos + 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [LB-1:0] act, input logic [LB-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison, before the driver changes inputs
  always @(negedge clk) begin
    if (rst_n) begin
      logic exp_ao, exp_bo;
      exp_ao = fill_dir ? !m_done : 1'b1;
      exp_bo = fill_dir ? 1'b1 : !m_done;
      check(line_o === m_line, "R2 line", line_o, m_line);
      check(in_ready === m_ready(), "R2 ready", LB'(in_ready), LB'(m_ready()));
      check(chain_a_o === exp_ao && chain_b_o === exp_bo, "R7 enable out",
            LB'({chain_a_o, chain_b_o}), LB'({exp_ao, exp_bo}));
      check(chain_a_oe === fill_dir && chain_b_oe === !fill_dir, "R6 roles",
            LB'({chain_a_oe, chain_b_oe}), LB'({fill_dir, !fill_dir}));
    end
  end

  task automatic cyc(input bit v, input logic [7:0] d);
    @(negedge clk);
    #1;
    in_valid = v;
    in_data  = d;
  endtask

  task automatic rewind();
    @(negedge clk);
    #1;
    in_valid = 0;
    line_start = 1;
    @(negedge clk);
    #1;
    line_start = 0;
  endtask

  task automatic fill(input int n, input int seed, input logic [7:0] first);
    for (int k = 0; k < n; k++) begin
      cyc(1, (k == 0) ? first : 8'((k * 37 + seed) & 8'hFF));
      if (k % 3 == 2) cyc(0, 8'h00);
    end
    cyc(0, 8'h00);
  endtask

  initial begin
    logic [LB-1:0] snap;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(line_o === '0, "R1 buffer clear", line_o, '0);
    check(chain_b_o === 1'b1 && in_ready === 1'b1, "R1 enable high, ready",
          LB'({chain_b_o, in_ready}), LB'(2'b11));

    // R3 wide, fill up
    cyc(1, 8'hC1);
    cyc(0, 8'h00);
    @(negedge clk);
    check(line_o[7:0] === 8'h83, "R3 first byte", LB'(line_o[7:0]), LB'(8'h83));
    fill(19, 5, 8'h5A);
    // R7 full: enable output low, extra word dropped
    check(chain_b_o === 1'b0 && in_ready === 1'b0, "R7 handed on",
          LB'({chain_b_o, in_ready}), LB'(2'b00));
    snap = line_o;
    cyc(1, 8'hFF); cyc(1, 8'h00); cyc(0, 8'h00);
    @(negedge clk);
    check(line_o === snap, "R7 extra dropped", line_o, snap);

    // R8 with line full: rewind plus offered word
    @(negedge clk); #1 line_start = 1; in_valid = 1; in_data = 8'hFF;
    @(negedge clk); #1 line_start = 0; in_valid = 0;
    @(negedge clk);
    check(line_o === snap, "R10 buffer kept", line_o, snap);
    check(chain_b_o === 1'b1 && in_ready === 1'b1, "R8 re-armed",
          LB'({chain_b_o, in_ready}), LB'(2'b11));

    // R5 wide, fill down
    fill_dir = 1;
    cyc(1, 8'hC1);
    cyc(0, 8'h00);
    @(negedge clk);
    check(line_o[159:152] === 8'hC1, "R5 first byte down", LB'(line_o[159:152]), LB'(8'hC1));
    fill(19, 11, 8'h3C);
    check(chain_a_o === 1'b0, "R7 down handed on", LB'(chain_a_o), '0);

    // R4 narrow, fill up, high bits garbage
    fill_dir = 0; bus_wide = 0;
    rewind();
    cyc(1, 8'hF2);
    cyc(0, 8'h00);
    @(negedge clk);
    check(line_o[3:0] === 4'h4, "R4 first nibble", LB'(line_o[3:0]), LB'(4'h4));
    fill(39, 23, 8'hE7);
    check(chain_b_o === 1'b0, "R4 40 nibbles fill", LB'(chain_b_o), '0);

    // R5 narrow, fill down
    fill_dir = 1;
    rewind();
    fill(40, 71, 8'h9D);
    check(chain_a_o === 1'b0, "R5 narrow down full", LB'(chain_a_o), '0);

    // R8 mid-line rewind colliding with a word
    bus_wide = 1; fill_dir = 0;
    rewind();
    fill(3, 90, 8'h11);
    snap = line_o;
    @(negedge clk); #1 line_start = 1; in_valid = 1; in_data = 8'hAA;
    @(negedge clk); #1 line_start = 0; in_valid = 0;
    @(negedge clk);
    check(line_o === snap, "R8 collided word dropped", line_o, snap);
    cyc(1, 8'h00); cyc(0, 8'h00);
    @(negedge clk);
    check(line_o[7:0] === 8'h00 && line_o[23:8] === snap[23:8],
          "R8 next word at start", line_o, {snap[LB-1:8], 8'h00});

    // R9 enable input high: no effect
    chain_a_i = 1;
    snap = line_o;
    cyc(1, 8'hFF); cyc(1, 8'h0F); cyc(0, 8'h00);
    @(negedge clk);
    check(line_o === snap && in_ready === 1'b0, "R9 disabled", line_o, snap);
    chain_a_i = 0;
    cyc(1, 8'hFF); cyc(0, 8'h00);
    @(negedge clk);
    check(line_o[15:8] === 8'hFF, "R9 position held", LB'(line_o[15:8]), LB'(8'hFF));

    // R6 roles, pin B ignored in direction low
    chain_b_i = 1;
    @(negedge clk);
    check(in_ready === 1'b1 && chain_b_oe === 1'b1 && chain_a_oe === 1'b0,
          "R6 pin B not an input", LB'({in_ready, chain_b_oe, chain_a_oe}), LB'(3'b110));
    fill_dir = 1; chain_a_i = 0;
    @(negedge clk);
    check(in_ready === 1'b0 && chain_a_oe === 1'b1, "R6 roles swap",
          LB'({in_ready, chain_a_oe}), LB'(2'b01));
    chain_b_i = 0;

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule